// File: doc/BRIEF.md
# Control-Word Field Edit Engine

The engine merges a numeric data field into a punctuation control word that sits in character storage. The result is written in place over the control word. Both fields are addressed by their low-order (highest) address and are scanned toward lower addresses. Each field ends at a character that carries a word mark. A one-character holding register carries the next data character from the cycle that fetches it to the cycle that stores it.

Work is split into A-cycles and B-cycles. An A-cycle reads the data field and loads the holding register. A B-cycle reads one control character, decides what goes back, and writes that result to the same address. A new data character is fetched only after the held one has been stored. Blank and zero control positions take data. Other control characters are kept or blanked according to the edit rules and the sign of the data.

A storage character is 8 bits: bit 7 word mark, bit 6 check bit, bit 5 B zone, bit 4 A zone, bits 3:0 digit. The low six bits are the character body. Character bodies used by the edit rules are: blank 6'b00_0000, zero 6'b00_1010, comma 6'b01_1011, ampersand 6'b11_0000, minus 6'b10_0000, C 6'b11_0011, R 6'b10_1001.

Top module: `edit_engine`

## Requirements
- R1: A start_i pulse while idle raises busy_o, and the first cycle after it is an A-cycle that reads the address on a_addr_i. No write happens in that cycle.
- R2: A blank or zero control position receives the body of the held data character while the data field is not yet used up, and an A-cycle follows. A data ampersand is stored like any other character.
- R3: Any other control character not covered by R4, R6 or R7 is written back with the same body. The next cycle is a B-cycle, so the held data character is kept for the next blank or zero position.
- R4: A control ampersand is written as blank and uses up no data character.
- R5: The operation ends on the B-cycle that reads the control character with the word mark. That position is written like any other, with the word mark cleared. done_o is high for exactly the one cycle after it, and busy_o is low from that cycle onward.
- R6: Once the data character that carried the A-field word mark has been stored, no more A-cycles occur. Every later zero, comma or blank control position is written as blank.
- R7: A minus, C or R in the control word before the first data character has been stored is kept when the data is negative and written as blank otherwise.
- R8: The data is negative only when the zone bits of its units (first-fetched) character are B=1, A=0. Every other zone combination counts as positive.
- R9: Both address registers step down by one on each cycle that uses them. The first B-cycle reads b_addr_i. Only B-field addresses are written, so the data field and all other storage are unchanged.
- R10: Every written character has odd parity over bits 6:0 and a clear word mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, honoured while idle |
| a_addr_i | input | AW | Low-order address of the data field |
| b_addr_i | input | AW | Low-order address of the control word |
| rd_addr_o | output | AW | Storage read address for the current cycle |
| rd_data_i | input | 8 | Storage read data, same cycle |
| wr_en_o | output | 1 | Storage write enable |
| wr_addr_o | output | AW | Storage write address |
| wr_data_o | output | 8 | Storage write data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end strobe |

## Verification
The assertions assume a few things about the inputs. Storage answers a read in the same cycle. The data field and the control word do not overlap. Each field has a word mark at its high-order end within the address range. start_i is not raised while the engine is busy. The stimulus builds every field with an explicit word mark at its high-order end and places the data field and control word in disjoint address ranges. It starts a new operation only after done_o is seen, and draws control characters from the edit-significant set plus ordinary punctuation.

// File: rtl/edit_pkg.sv
package edit_pkg;
  localparam int CW = 8;
  localparam int BW = 6;
  localparam logic [BW-1:0] BODY_BLANK = 6'b00_0000;
  localparam logic [BW-1:0] BODY_ZERO  = 6'b00_1010;
  localparam logic [BW-1:0] BODY_COMMA = 6'b01_1011;
  localparam logic [BW-1:0] BODY_AMP   = 6'b11_0000;
  localparam logic [BW-1:0] BODY_MINUS = 6'b10_0000;
  localparam logic [BW-1:0] BODY_C     = 6'b11_0011;
  localparam logic [BW-1:0] BODY_R     = 6'b10_1001;

  typedef enum logic [1:0] {ST_IDLE, ST_ACYC, ST_BCYC} edit_st_e;

  typedef struct packed {
    logic blank;
    logic zero;
    logic comma;
    logic amp;
    logic sign;
  } ctl_cls_t;
endpackage

// File: rtl/edit_classify.sv
module edit_classify
  import edit_pkg::*;
(
  input  logic [BW-1:0] body_i,
  output ctl_cls_t      cls_o
);
  always_comb begin
    cls_o.blank = (body_i == BODY_BLANK);
    cls_o.zero  = (body_i == BODY_ZERO);
    cls_o.comma = (body_i == BODY_COMMA);
    cls_o.amp   = (body_i == BODY_AMP);
    cls_o.sign  = (body_i == BODY_MINUS) || (body_i == BODY_C) || (body_i == BODY_R);
  end
endmodule

// File: rtl/edit_parity.sv
module edit_parity
  import edit_pkg::*;
(
  input  logic [BW-1:0] body_i,
  output logic [CW-1:0] char_o
);
  // word mark cleared, check bit makes bits 6:0 odd
  assign char_o = {1'b0, ~^body_i, body_i};
endmodule

// File: rtl/edit_seq.sv
module edit_seq
  import edit_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] a_addr_i,
  input  logic [AW-1:0] b_addr_i,
  input  logic          rd_wm_i,
  input  logic [BW-1:0] rd_body_i,
  input  ctl_cls_t      cls_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          wr_en_o,
  output logic [BW-1:0] wr_body_o,
  output logic          busy_o,
  output logic          done_o
);
  edit_st_e      st_q;
  logic [AW-1:0] a_ptr_q, b_ptr_q;
  logic [BW-1:0] hold_q;
  logic          neg_q, a_wm_q, data_done_q, placed_q, first_a_q;

  logic fill;
  assign fill      = (st_q == ST_BCYC) && (cls_i.blank || cls_i.zero) && !data_done_q;
  assign rd_addr_o = (st_q == ST_ACYC) ? a_ptr_q : b_ptr_q;
  assign wr_en_o   = (st_q == ST_BCYC);
  assign busy_o    = (st_q != ST_IDLE);

  always_comb begin
    if (fill)
      wr_body_o = hold_q;
    else if (data_done_q && (cls_i.blank || cls_i.zero || cls_i.comma))
      wr_body_o = BODY_BLANK;
    else if (cls_i.amp)
      wr_body_o = BODY_BLANK;
    else if (cls_i.sign && !placed_q)
      wr_body_o = neg_q ? rd_body_i : BODY_BLANK;
    else
      wr_body_o = rd_body_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      a_ptr_q     <= '0;
      b_ptr_q     <= '0;
      hold_q      <= '0;
      neg_q       <= 1'b0;
      a_wm_q      <= 1'b0;
      data_done_q <= 1'b0;
      placed_q    <= 1'b0;
      first_a_q   <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q        <= ST_ACYC;
          a_ptr_q     <= a_addr_i;
          b_ptr_q     <= b_addr_i;
          neg_q       <= 1'b0;
          a_wm_q      <= 1'b0;
          data_done_q <= 1'b0;
          placed_q    <= 1'b0;
          first_a_q   <= 1'b1;
        end
        ST_ACYC: begin
          hold_q    <= rd_body_i;
          a_wm_q    <= rd_wm_i;
          a_ptr_q   <= a_ptr_q - 1'b1;
          first_a_q <= 1'b0;
          if (first_a_q) neg_q <= (rd_body_i[5:4] == 2'b10);
          st_q <= ST_BCYC;
        end
        ST_BCYC: begin
          b_ptr_q <= b_ptr_q - 1'b1;
          if (fill) begin
            placed_q <= 1'b1;
            if (a_wm_q) data_done_q <= 1'b1;
          end
          if (rd_wm_i) begin
            st_q   <= ST_IDLE;
            done_o <= 1'b1;
          end else if (fill && !a_wm_q) begin
            st_q <= ST_ACYC;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_START_TO_ACYC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && start_i) |=> (st_q == ST_ACYC && rd_addr_o == $past(a_addr_i))); // R1
  AST_A_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ACYC) |=> (a_ptr_q == $past(a_ptr_q) - 1'b1)); // R9
  AST_B_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BCYC && !rd_wm_i) |=> (rd_addr_o == $past(rd_addr_o) - 1'b1 || st_q == ST_ACYC)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R5
  AST_NO_FETCH_AFTER_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_done_q |-> (st_q != ST_ACYC)); // R6
  AST_KEEP_NEXT_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BCYC && !fill && !rd_wm_i) |=> (st_q == ST_BCYC)); // R3
endmodule

// File: rtl/edit_engine.sv
module edit_engine
  import edit_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] a_addr_i,
  input  logic [AW-1:0] b_addr_i,
  output logic [AW-1:0] rd_addr_o,
  input  logic [7:0]    rd_data_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic          busy_o,
  output logic          done_o
);
  ctl_cls_t      cls;
  logic [BW-1:0] wr_body;

  edit_classify u_cls (
    .body_i (rd_data_i[BW-1:0]),
    .cls_o  (cls)
  );

  edit_seq #(.AW(AW)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .a_addr_i  (a_addr_i),
    .b_addr_i  (b_addr_i),
    .rd_wm_i   (rd_data_i[CW-1]),
    .rd_body_i (rd_data_i[BW-1:0]),
    .cls_i     (cls),
    .rd_addr_o (rd_addr_o),
    .wr_en_o   (wr_en_o),
    .wr_body_o (wr_body),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  edit_parity u_par (
    .body_i (wr_body),
    .char_o (wr_data_o)
  );

  assign wr_addr_o = rd_addr_o;

  AST_WR_ODD_PARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (^wr_data_o[6:0])); // R10
  AST_WR_NO_WM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> !wr_data_o[7]); // R5
  AST_WR_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> busy_o); // R9
endmodule

// File: tb/sim_edit_engine.sv
module sim_edit_engine;
  localparam int AW = 8;
  localparam int MD = 256;
  localparam logic [5:0] B_BLANK = 6'b00_0000, B_ZERO = 6'b00_1010, B_COMMA = 6'b01_1011,
                         B_AMP = 6'b11_0000, B_MINUS = 6'b10_0000, B_C = 6'b11_0011,
                         B_R = 6'b10_1001, B_DOT = 6'b11_1011, B_DOLLAR = 6'b10_1011;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] a_addr = '0, b_addr = '0, rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data;
  logic wr_en, busy, done;
  logic [7:0] mem [MD];
  logic [7:0] exp_mem [MD];
  int n_chk = 0, n_fail = 0, par_err = 0, cyc = 0;
  logic [5:0] dat [16];
  logic [5:0] ctl [32];

  always #2.5 clk = ~clk;

  edit_engine #(.AW(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .a_addr_i(a_addr), .b_addr_i(b_addr),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .busy_o(busy), .done_o(done)
  );

  assign rd_data = mem[rd_addr];
  always @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
      if (!(^wr_data[6:0]) || wr_data[7]) par_err++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  function automatic logic [7:0] mk(input logic [5:0] body, input logic wm);
    return {wm, ~^body, body};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, expv);
    end
  endtask

  // spec model of the edit on exp_mem
  task automatic model(input int aa, input int bb);
    int a = aa, b = bb;
    logic [5:0] held = '0, c, o;
    bit neg = 0, awm = 0, ddone = 0, placed = 0, need_a = 1, first = 1, wm, isfill;
    forever begin
      if (need_a) begin
        held = exp_mem[a][5:0]; awm = exp_mem[a][7];
        if (first) neg = (held[5:4] == 2'b10);
        first = 0; a--; need_a = 0;
      end
      c = exp_mem[b][5:0]; wm = exp_mem[b][7];
      isfill = (c == B_BLANK || c == B_ZERO) && !ddone;
      if (isfill) o = held;
      else if (ddone && (c == B_BLANK || c == B_ZERO || c == B_COMMA)) o = B_BLANK;
      else if (c == B_AMP) o = B_BLANK;
      else if ((c == B_MINUS || c == B_C || c == B_R) && !placed) o = neg ? c : B_BLANK;
      else o = c;
      exp_mem[b] = mk(o, 1'b0);
      b--;
      if (isfill) begin
        placed = 1;
        if (awm) ddone = 1; else need_a = 1;
      end
      if (wm) break;
    end
  endtask

  // field index 0 is high order (word mark), last is low order at addr
  task automatic run(input string req, input int aa, input int na, input int bb, input int nb);
    int t = 0, bad = 0, first_bad = -1;
    for (int i = 0; i < na; i++) mem[aa - na + 1 + i] = mk(dat[i], i == 0);
    for (int i = 0; i < nb; i++) mem[bb - nb + 1 + i] = mk(ctl[i], i == 0);
    for (int i = 0; i < MD; i++) exp_mem[i] = mem[i];
    model(aa, bb);
    @(negedge clk);
    a_addr = aa[AW-1:0]; b_addr = bb[AW-1:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && rd_addr == aa[AW-1:0] && !wr_en, "R1 first A-cycle", rd_addr, aa);
    @(negedge clk);
    chk(rd_addr == bb[AW-1:0] && wr_en, "R9 first B-cycle address", rd_addr, bb);
    while (!done && t < 2000) begin @(negedge clk); t++; end
    chk(done, "R5 done strobe", done, 1);
    chk(!busy, "R5 idle at done", busy, 0);
    @(negedge clk);
    chk(!done, "R5 done one cycle", done, 0);
    for (int i = 0; i < MD; i++)
      if (mem[i] !== exp_mem[i]) begin bad++; if (first_bad < 0) first_bad = i; end
    if (first_bad < 0) first_bad = 0;
    chk(bad == 0, req, mem[first_bad], exp_mem[first_bad]);
    chk(par_err == 0, "R10 written parity and word mark", par_err, 0);
  endtask

  function automatic logic [5:0] rdigit();
    int d = $urandom_range(0, 9);
    return (d == 0) ? B_ZERO : 6'(d);
  endfunction

  initial begin
    void'($urandom(32'd1401));
    for (int i = 0; i < MD; i++) mem[i] = mk(6'($urandom_range(1, 63)), 1'b0);
    #12;
    chk(!busy && !done && !wr_en, "R1 reset idle", {busy, done, wr_en}, 0);
    rst_n = 1'b1;

    // R2 R3: plain digits into blanks around kept punctuation
    dat[0] = 6'd1; dat[1] = 6'd2; dat[2] = 6'd3;
    ctl[0] = B_BLANK; ctl[1] = B_COMMA; ctl[2] = B_BLANK; ctl[3] = B_DOT; ctl[4] = B_ZERO; ctl[5] = B_BLANK;
    run("R2 R3 fill and keep", 40, 3, 150, 6);
    // R7 R8 negative: units zone B only, sign symbols kept
    dat[0] = 6'd4; dat[1] = 6'b10_0101;
    ctl[0] = B_BLANK; ctl[1] = B_BLANK; ctl[2] = B_MINUS; ctl[3] = B_C; ctl[4] = B_R;
    run("R7 R8 negative sign kept", 50, 2, 160, 5);
    // R7 R8 positive: zones B and A, sign blanked
    dat[0] = 6'd4; dat[1] = 6'b11_0101;
    run("R7 R8 positive sign blanked", 50, 2, 160, 5);
    // R8 positive with A zone only
    dat[1] = 6'b01_0101;
    run("R8 A-zone counts positive", 50, 2, 160, 5);
    // R4 control ampersand consumes no data
    dat[0] = 6'd7; dat[1] = 6'd8;
    ctl[0] = B_BLANK; ctl[1] = B_AMP; ctl[2] = B_BLANK; ctl[3] = B_AMP;
    run("R4 ampersand to blank", 60, 2, 170, 4);
    // R6 short data: later zeros, commas, blanks become blank
    dat[0] = 6'd9;
    ctl[0] = B_ZERO; ctl[1] = B_COMMA; ctl[2] = B_BLANK; ctl[3] = B_ZERO; ctl[4] = B_DOLLAR; ctl[5] = B_BLANK;
    run("R6 exhausted data blanks", 70, 1, 180, 6);
    // R2 data ampersand stored as ordinary
    dat[0] = B_AMP; dat[1] = 6'd5;
    ctl[0] = B_BLANK; ctl[1] = B_BLANK;
    run("R2 data ampersand stored", 80, 2, 190, 2);
    // R5 single-position control word
    dat[0] = 6'd3; ctl[0] = B_BLANK;
    run("R5 one-position control", 90, 1, 200, 1);

    for (int k = 0; k < 40; k++) begin
      int na = $urandom_range(1, 8), nb = $urandom_range(1, 20);
      for (int i = 0; i < na; i++) dat[i] = ($urandom_range(0, 9) == 0) ? B_AMP : rdigit();
      dat[na-1][5:4] = 2'($urandom_range(0, 3));
      for (int i = 0; i < nb; i++) begin
        case ($urandom_range(0, 9))
          0, 1, 2: ctl[i] = B_BLANK;
          3: ctl[i] = B_ZERO;
          4: ctl[i] = B_COMMA;
          5: ctl[i] = B_AMP;
          6: ctl[i] = B_MINUS;
          7: ctl[i] = B_C;
          8: ctl[i] = B_R;
          default: ctl[i] = B_DOT;
        endcase
      end
      run("R2 R3 R4 R6 R7 R9 random", 40 + $urandom_range(0, 20), na, 150 + $urandom_range(0, 60), nb);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule